// File: doc/BRIEF.md
# Audio PWM Timebase with Buffered Duty

This block makes a pulse-width modulated output from a free-running counter and produces a periodic update strobe. It is meant for audio playback. A sample source writes the next 7-bit level into a holding register at any time. The block moves that level into the active comparator only when the update strobe fires, so every new level starts exactly on a period boundary and no edge is late or early.

Each period is built from three nested counters:

- **Prescaler:** runs from the system clock and divides by 1, 4 or 16.
- **Sub-phase counter:** 2 bits, advanced by each prescaler enable.
- **Coarse counter:** counts up to a programmable limit. A 4-bit postscaler counts completed periods and raises the update strobe.

The 5 upper duty bits compare against the coarse count and the 2 low bits against the sub-phase. The duty therefore has four times the resolution of the coarse period. With a period of 32, a 7-bit sample maps straight onto the duty.

Top module: `audio_pwm_timebase`

## Requirements
- R1: `pre_sel` picks the clock divide: code 0 divides by 1, code 1 by 4, codes 2 and 3 by 16. One PWM period lasts 4 × divide × (`period_m1` + 1) clock cycles.
- R2: `period_m1` holds the coarse period minus one, from 0 (period 1) to 255 (period 256).
- R3: `tick` is high for exactly one clock cycle, in the last cycle of every (`post_m1` + 1)-th PWM period. `post_m1` is a 4-bit field holding the postscale count minus one.
- R4: `pwm_out` is high while {coarse count, 2-bit sub-phase} is below the active duty. Each period therefore holds min(duty, 4 × period) × divide high cycles, starting at the first cycle of the period.
- R5: An active duty of 0 keeps `pwm_out` low for the whole period. A duty of at least 4 × period keeps it high for the whole period.
- R6: A write to the holding register changes nothing in the running period. At the clock edge that ends a `tick` cycle, the held value becomes the active duty for the next period.
- R7: A write made in a cycle where `tick` is high lands in the holding register only. The active duty for the next period is the value held before that write, and the new value takes effect one update later.
- R8: After reset, the active and held duty are both 64 (mid-scale, zero signal), `tick` is low and all counters are zero. The first `tick` therefore comes in the last cycle of the first full postscale span.
- R9: After a `tick` cycle, the coarse count and sub-phase both restart at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescaler code: 0 = divide by 1, 1 = divide by 4, 2 and 3 = divide by 16 |
| period_m1 | input | 8 | Coarse period minus one |
| post_m1 | input | 4 | Periods per update tick, minus one |
| duty_in | input | 7 | Next duty level to hold |
| duty_we | input | 1 | Write strobe for `duty_in` |
| pwm_out | output | 1 | PWM output |
| tick | output | 1 | One-cycle update strobe |

## Verification
The table of vectors covers every prescaler code, including the alias code 3. It also covers periods at both ends of the range (1 and 256) and both ends of the postscaler range (1 and 16). Duties include 0, small odd values that exercise only the fractional bits, and values above the period span.

Counting the high cycles of one period separates a wrong divide from a wrong fractional compare. The position of the strobe within the span separates period errors from postscale errors.

Directed sequences write the holding register at three points:
- In the strobe cycle, which shows the one-update delay.
- Mid-period, which shows that the write does not touch the running period.
- Right after reset, which shows the mid-scale reset level and the full-length first span.

// File: rtl/apwm_pkg.sv
package apwm_pkg;

  localparam int FRAC_W  = 2;
  localparam int MAX_PRE = 16;

  // clock divide selected by the 2-bit prescaler code
  function automatic int unsigned pre_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      default: return 16;
    endcase
  endfunction

  // output level for a position within the period against a duty
  function automatic logic level_high(input int unsigned pos, input int unsigned duty);
    return pos < duty;
  endfunction

  // mid-scale level for a duty of a given width
  function automatic int unsigned mid_level(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/apwm_prescale.sv
module apwm_prescale #(
  parameter int MAX_PRE = apwm_pkg::MAX_PRE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  output logic       pre_en
);
  localparam int PRE_W = $clog2(MAX_PRE);

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] limit;

  assign limit  = PRE_W'(apwm_pkg::pre_ratio(sel) - 1);
  // >= keeps the count bounded when the code shrinks at run time
  assign pre_en = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (pre_en) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/apwm_counter.sv
module apwm_counter #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pre_en,
  input  logic [CNT_W-1:0]             period_m1,
  input  logic [POST_W-1:0]            post_m1,
  output logic [apwm_pkg::FRAC_W-1:0]  phase,
  output logic [CNT_W-1:0]             timer,
  output logic                         period_end,
  output logic                         tick
);
  localparam int FW = apwm_pkg::FRAC_W;

  logic [FW-1:0]     phase_q;
  logic [CNT_W-1:0]  timer_q;
  logic [POST_W-1:0] post_q;
  logic              step_coarse;

  assign step_coarse = pre_en && (phase_q == {FW{1'b1}});
  assign period_end  = step_coarse && (timer_q >= period_m1);
  assign tick        = period_end && (post_q >= post_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      timer_q <= '0;
      post_q  <= '0;
    end else begin
      if (pre_en) phase_q <= phase_q + 1'b1;
      if (period_end)       timer_q <= '0;
      else if (step_coarse) timer_q <= timer_q + 1'b1;
      if (tick)             post_q <= '0;
      else if (period_end)  post_q <= post_q + 1'b1;
    end
  end

  assign phase = phase_q;
  assign timer = timer_q;
endmodule

// File: rtl/apwm_duty.sv
module apwm_duty #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic                         we,
  input  logic [DUTY_W-1:0]            wdata,
  input  logic [CNT_W-1:0]             timer,
  input  logic [apwm_pkg::FRAC_W-1:0]  phase,
  output logic [DUTY_W-1:0]            active,
  output logic [DUTY_W-1:0]            shadow,
  output logic                         pwm
);
  localparam int          POS_W = CNT_W + apwm_pkg::FRAC_W;
  localparam logic [DUTY_W-1:0] MID = DUTY_W'(apwm_pkg::mid_level(DUTY_W));

  logic [DUTY_W-1:0] active_q, shadow_q;
  logic [POS_W-1:0]  pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= MID;
      shadow_q <= MID;
    end else begin
      if (load) active_q <= shadow_q;  // old held value, even if written now
      if (we)   shadow_q <= wdata;
    end
  end

  assign pos    = {timer, phase};
  assign pwm    = apwm_pkg::level_high(32'(pos), 32'(active_q));
  assign active = active_q;
  assign shadow = shadow_q;
endmodule

// File: rtl/audio_pwm_timebase.sv
module audio_pwm_timebase #(
  parameter int CNT_W  = 8,
  parameter int POST_W = 4,
  parameter int DUTY_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        pre_sel,
  input  logic [CNT_W-1:0]  period_m1,
  input  logic [POST_W-1:0] post_m1,
  input  logic [DUTY_W-1:0] duty_in,
  input  logic              duty_we,
  output logic              pwm_out,
  output logic              tick
);
  localparam int FW = apwm_pkg::FRAC_W;

  logic              pre_en;
  logic [FW-1:0]     phase_w;
  logic [CNT_W-1:0]  timer_w;
  logic              period_end_w;
  logic              load_evt;
  logic [DUTY_W-1:0] active_duty;
  logic [DUTY_W-1:0] shadow_duty;

  apwm_prescale u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (pre_sel),
    .pre_en (pre_en)
  );

  apwm_counter #(.CNT_W(CNT_W), .POST_W(POST_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .pre_en     (pre_en),
    .period_m1  (period_m1),
    .post_m1    (post_m1),
    .phase      (phase_w),
    .timer      (timer_w),
    .period_end (period_end_w),
    .tick       (load_evt)
  );

  apwm_duty #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_duty (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_evt),
    .we     (duty_we),
    .wdata  (duty_in),
    .timer  (timer_w),
    .phase  (phase_w),
    .active (active_duty),
    .shadow (shadow_duty),
    .pwm    (pwm_out)
  );

  assign tick = load_evt;
endmodule

// File: rtl/audio_pwm_timebase_chk.sv
module audio_pwm_timebase_chk #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              pwm,
  input logic              period_end,
  input logic [DUTY_W-1:0] active,
  input logic [DUTY_W-1:0] shadow,
  input logic [CNT_W-1:0]  timer,
  input logic [1:0]        phase
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R3
  tick_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> period_end);

  // R9
  tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (timer == '0 && phase == 2'd0));

  // R6
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(active));

  // R7
  active_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (active == $past(shadow)));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |-> !pwm);
endmodule

bind audio_pwm_timebase audio_pwm_timebase_chk #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .pwm        (pwm_out),
  .period_end (period_end_w),
  .active     (active_duty),
  .shadow     (shadow_duty),
  .timer      (timer_w),
  .phase      (phase_w)
);

// File: tb/audio_pwm_timebase_test.sv
`timescale 1ns/1ps
module audio_pwm_timebase_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [7:0] period_m1 = 8'd31;
  logic [3:0] post_m1 = 4'd0;
  logic [6:0] duty_in = 7'd0;
  logic       duty_we = 1'b0;
  logic       pwm_out, tick;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  audio_pwm_timebase uut (
    .clk(clk), .rst_n(rst_n), .pre_sel(pre_sel), .period_m1(period_m1),
    .post_m1(post_m1), .duty_in(duty_in), .duty_we(duty_we),
    .pwm_out(pwm_out), .tick(tick)
  );

  // pre_sel, period_m1, post_m1, duty
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0, 31,  1,  64},
    '{1,  7,  2,   5},
    '{2,  3,  0, 127},
    '{0, 31, 15,   0},
    '{0,  0,  0,   3},
    '{0, 255, 0, 100},
    '{3,  1,  1,   9},
    '{1, 31,  0,   1}
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int divide_of(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  // walk len cycles from the current falling edge; highs counted over the first p
  task automatic run(input int len, input int p, input int wr_at, input int wr_val,
                     output int highs, output int first_tick, output int ticks);
    highs = 0; first_tick = -1; ticks = 0;
    for (int i = 0; i < len; i++) begin
      if (i < p && pwm_out) highs++;
      if (tick) begin
        ticks++;
        if (first_tick < 0) first_tick = i;
      end
      if (i == wr_at) begin
        duty_in = 7'(wr_val);
        duty_we = 1'b1;
      end
      @(negedge clk);
      duty_we = 1'b0;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    duty_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int h, ft, tc;
    @(negedge clk);

    // reset state and first span, R8
    pre_sel = 2'd0; period_m1 = 8'd31; post_m1 = 4'd1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 tick in reset", int'(tick), 0);
    check("R8 pwm in reset (mid duty)", int'(pwm_out), 1);
    rst_n = 1'b1;
    run(256, 128, -1, 0, h, ft, tc);
    check("R8 highs at reset duty 64", h, 64);
    check("R8 first tick after full span", ft, 255);

    // table of vectors: R1 R2 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      int div, per, p, span, dut, eh;
      pre_sel = 2'(VEC[v][0]);
      period_m1 = 8'(VEC[v][1]);
      post_m1 = 4'(VEC[v][2]);
      div = divide_of(VEC[v][0]);
      per = VEC[v][1] + 1;
      p = 4 * div * per;
      span = p * (VEC[v][2] + 1);
      dut = VEC[v][3];
      eh = ((dut > 4 * per) ? 4 * per : dut) * div;
      do_reset();
      run(span, 0, 0, dut, h, ft, tc);
      run(span, p, -1, 0, h, ft, tc);
      check($sformatf("R4 R5 highs vec%0d", v), h, eh);
      check($sformatf("R1 R2 R3 tick position vec%0d", v), ft, span - 1);
      check($sformatf("R3 one tick per span vec%0d", v), tc, 1);
    end

    // holding register timing: R6 R7 R9
    pre_sel = 2'd0; period_m1 = 8'd31; post_m1 = 4'd0;
    do_reset();
    run(128, 0, 0, 40, h, ft, tc);
    run(128, 128, 127, 90, h, ft, tc);     // write in tick cycle
    check("R6 duty 40 loaded at tick", h, 40);
    check("R9 tick at period end", ft, 127);
    run(128, 128, -1, 0, h, ft, tc);
    check("R7 tick-cycle write delayed one update", h, 40);
    run(128, 128, 20, 10, h, ft, tc);      // mid-period write
    check("R6 mid-period write ignored", h, 90);
    run(128, 128, -1, 0, h, ft, tc);
    check("R6 held value applied next period", h, 10);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule